// File: doc/BRIEF.md
# Opcode-Feeding Block Capture Buffer

This block sits in the read data path between a memory bus and an 8-bit 6502-style CPU. Most of the time it is a transparent read buffer: whatever memory drives on its data bus is handed to the CPU unchanged. The CPU can ask it to copy a block of memory without running a copy loop. Software pulses an arm line and then immediately calls a subroutine at the start of the block. The block lets the six cycles of that JSR pass untouched. From the next opcode fetch onward it captures every byte that memory returns and hands the CPU a filler opcode in its place. Either a two-byte load immediate or a single-cycle NOP will do, and with either one the program counter walks through the block one byte per bus cycle.

After the last byte of the block, the next opcode fetch receives a return-from-subroutine opcode. A one-clock done pulse follows and the block goes back to passthrough. Captured bytes leave through a simple write port (address, data, strobe) to an external buffer. With the default 8192-byte block and a 2 MHz bus, one copy takes about 4 ms of CPU time.

The block runs on a fast system clock. The bus clock phi2 and the other CPU strobes arrive as inputs synchronous to it. Each bus cycle is processed at the falling edge of phi2, using values latched while phi2 was high.

Top module: `opfeed_capture`

## Requirements
- R1: Outside a copy, cpu_data_o equals mem_data_i at all times.
- R2: cpu_data_o is replaced only while phi2_i is high and rw_i is high. While phi2_i is low, it equals mem_data_i.
- R3: After arm_i is seen high during a bus cycle, the next read cycle with sync_i high starts a six-cycle JSR window. All six cycles pass memory data through, and capture starts on the opcode fetch that follows the window.
- R4: During a copy, each read cycle inside the block presents the filler opcode 8'hA0 to the CPU while phi2_i is high.
- R5: During a copy, each read cycle inside the block writes the real memory byte to the capture port. Each write is a one-clock cap_we_o strobe. Addresses run 0, 1, 2 … BLOCK_LEN-1 in fetch order.
- R6: Bus cycles with rw_i low are never overridden and never captured.
- R7: Once BLOCK_LEN bytes have been captured, the next read cycle with sync_i high presents 8'h60. A non-sync read cycle before that presents the filler. Neither of these cycles is captured.
- R8: One clock after the bus cycle that delivered 8'h60, done_o pulses high for one clock, and the block returns to passthrough.
- R9: arm_i is ignored from the moment a copy is armed until done_o. Arming during a copy does not start a second copy.
- R10: With USE_NOP_FILLER set, the filler is the single-cycle opcode 8'h03 instead of 8'hA0. Every fetch is then an opcode fetch, and 8'h60 follows directly after the last block byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than phi2 |
| rst_ni | input | 1 | Asynchronous active-low reset |
| phi2_i | input | 1 | CPU bus clock phase 2, synchronous to clk_i |
| sync_i | input | 1 | High on CPU opcode fetch cycles |
| rw_i | input | 1 | CPU read (1) / write (0) |
| arm_i | input | 1 | Requests a copy on the next JSR |
| mem_data_i | input | 8 | Data from memory |
| cpu_data_o | output | 8 | Data presented to the CPU |
| cap_we_o | output | 1 | Capture write strobe |
| cap_addr_o | output | ADDR_W | Capture address (13 bits by default) |
| cap_data_o | output | 8 | Captured memory byte |
| done_o | output | 1 | One-clock pulse after the return opcode |

## Verification
Random idle traffic, with mixed sync and rw values and random memory bytes, checks that nothing is overridden outside a copy and that nothing changes during phi2-low. Full copies with random block contents are driven by a bench CPU model. The model chooses each next fetch type from the opcode it was just handed. An odd block length with the two-byte filler brings the last byte onto an opcode fetch, so an extra filler cycle is needed. The single-cycle NOP variant puts the return opcode right after the block, which separates the two end-of-block paths. Write cycles and stray arm pulses are placed in the middle of copies, and the bench checks afterwards that they changed neither the capture stream nor the later passthrough.

// File: rtl/opfeed_pkg.sv
package opfeed_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_JSR,
    ST_COPY
  } opfeed_state_e;

  localparam logic [7:0] OP_RTS     = 8'h60;
  localparam logic [7:0] OP_LDY_IMM = 8'hA0;
  localparam logic [7:0] OP_NOP1    = 8'h03;
endpackage

// File: rtl/opfeed_sampler.sv
module opfeed_sampler (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       phi2_i,
  input  logic       sync_i,
  input  logic       rw_i,
  input  logic       arm_i,
  input  logic [7:0] data_i,
  output logic       cyc_end_o,
  output logic       sync_q_o,
  output logic       rw_q_o,
  output logic       arm_q_o,
  output logic [7:0] data_q_o
);
  logic phi2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phi2_q   <= 1'b0;
      sync_q_o <= 1'b0;
      rw_q_o   <= 1'b1;
      arm_q_o  <= 1'b0;
      data_q_o <= 8'h00;
    end else begin
      phi2_q <= phi2_i;
      // hold the last phi2-high view of the bus for end-of-cycle processing
      if (phi2_i) begin
        sync_q_o <= sync_i;
        rw_q_o   <= rw_i;
        arm_q_o  <= arm_i;
        data_q_o <= data_i;
      end
    end
  end

  assign cyc_end_o = phi2_q & ~phi2_i;
endmodule

// File: rtl/opfeed_seq.sv
module opfeed_seq
  import opfeed_pkg::*;
#(
  parameter int BLOCK_LEN  = 8192,
  parameter int JSR_CYCLES = 6,
  parameter int CNT_W      = 14,
  parameter int ADDR_W     = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_end_i,
  input  logic              sync_q_i,
  input  logic              rw_q_i,
  input  logic              arm_q_i,
  output logic              copy_o,
  output logic              started_o,
  output logic              at_end_o,
  output logic              cap_fire_o,
  output logic [ADDR_W-1:0] cap_idx_o,
  output logic              done_fire_o
);
  localparam int JW = $clog2(JSR_CYCLES + 1);

  opfeed_state_e    state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic [JW-1:0]    jcnt_q;

  assign copy_o    = (state_q == ST_COPY);
  assign started_o = (cnt_q != '0);
  assign at_end_o  = (cnt_q == CNT_W'(BLOCK_LEN));
  assign cap_idx_o = cnt_q[ADDR_W-1:0];

  assign cap_fire_o  = cyc_end_i & copy_o & rw_q_i & ~at_end_o & (started_o | sync_q_i);
  assign done_fire_o = cyc_end_i & copy_o & rw_q_i & at_end_o & sync_q_i;

  always_comb begin
    state_d = state_q;
    if (cyc_end_i) begin
      unique case (state_q)
        ST_IDLE:  if (arm_q_i) state_d = ST_ARMED;
        ST_ARMED: if (sync_q_i && rw_q_i) state_d = ST_JSR;
        ST_JSR:   if (jcnt_q == JW'(JSR_CYCLES - 1)) state_d = ST_COPY;
        ST_COPY:  if (done_fire_o) state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      jcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      if (cyc_end_i && state_q == ST_ARMED) jcnt_q <= JW'(1);
      else if (cyc_end_i && state_q == ST_JSR) jcnt_q <= jcnt_q + JW'(1);
      if (cyc_end_i && state_q == ST_JSR) cnt_q <= '0;
      else if (cap_fire_o) cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/opfeed_capwr.sv
module opfeed_capwr #(
  parameter int ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_fire_i,
  input  logic [ADDR_W-1:0] cap_idx_i,
  input  logic [7:0]        data_q_i,
  input  logic              done_fire_i,
  output logic              cap_we_o,
  output logic [ADDR_W-1:0] cap_addr_o,
  output logic [7:0]        cap_data_o,
  output logic              done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_we_o   <= 1'b0;
      cap_addr_o <= '0;
      cap_data_o <= 8'h00;
      done_o     <= 1'b0;
    end else begin
      cap_we_o <= cap_fire_i;
      done_o   <= done_fire_i;
      if (cap_fire_i) begin
        cap_addr_o <= cap_idx_i;
        cap_data_o <= data_q_i;
      end
    end
  end
endmodule

// File: rtl/opfeed_mux.sv
module opfeed_mux
  import opfeed_pkg::*;
#(
  parameter logic [7:0] FILLER = OP_LDY_IMM
) (
  input  logic       phi2_i,
  input  logic       rw_i,
  input  logic       sync_i,
  input  logic       copy_i,
  input  logic       started_i,
  input  logic       at_end_i,
  input  logic [7:0] mem_data_i,
  output logic [7:0] cpu_data_o
);
  logic       take;
  logic [7:0] inject;

  // ret only on an opcode fetch; operand cycles past the block get filler
  assign inject = (at_end_i && sync_i) ? OP_RTS : FILLER;
  assign take   = phi2_i & rw_i & copy_i & (started_i | sync_i);

  assign cpu_data_o = take ? inject : mem_data_i;
endmodule

// File: rtl/opfeed_capture.sv
module opfeed_capture
  import opfeed_pkg::*;
#(
  parameter int         BLOCK_LEN      = 8192,
  parameter int         JSR_CYCLES     = 6,
  parameter bit         USE_NOP_FILLER = 1'b0,
  parameter logic [7:0] NOP_OPCODE     = OP_NOP1,
  parameter int         ADDR_W         = $clog2(BLOCK_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              phi2_i,
  input  logic              sync_i,
  input  logic              rw_i,
  input  logic              arm_i,
  input  logic [7:0]        mem_data_i,
  output logic [7:0]        cpu_data_o,
  output logic              cap_we_o,
  output logic [ADDR_W-1:0] cap_addr_o,
  output logic [7:0]        cap_data_o,
  output logic              done_o
);
  localparam int CNT_W = ADDR_W + 1;

  logic              cyc_end, sync_q, rw_q, arm_q;
  logic [7:0]        data_q;
  logic              copy, started, at_end, cap_fire, done_fire;
  logic [ADDR_W-1:0] cap_idx;

  opfeed_sampler u_sampler (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phi2_i    (phi2_i),
    .sync_i    (sync_i),
    .rw_i      (rw_i),
    .arm_i     (arm_i),
    .data_i    (mem_data_i),
    .cyc_end_o (cyc_end),
    .sync_q_o  (sync_q),
    .rw_q_o    (rw_q),
    .arm_q_o   (arm_q),
    .data_q_o  (data_q)
  );

  opfeed_seq #(
    .BLOCK_LEN  (BLOCK_LEN),
    .JSR_CYCLES (JSR_CYCLES),
    .CNT_W      (CNT_W),
    .ADDR_W     (ADDR_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cyc_end_i   (cyc_end),
    .sync_q_i    (sync_q),
    .rw_q_i      (rw_q),
    .arm_q_i     (arm_q),
    .copy_o      (copy),
    .started_o   (started),
    .at_end_o    (at_end),
    .cap_fire_o  (cap_fire),
    .cap_idx_o   (cap_idx),
    .done_fire_o (done_fire)
  );

  opfeed_capwr #(.ADDR_W(ADDR_W)) u_capwr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_fire_i  (cap_fire),
    .cap_idx_i   (cap_idx),
    .data_q_i    (data_q),
    .done_fire_i (done_fire),
    .cap_we_o    (cap_we_o),
    .cap_addr_o  (cap_addr_o),
    .cap_data_o  (cap_data_o),
    .done_o      (done_o)
  );

  generate
    if (USE_NOP_FILLER) begin : g_nop_fill
      opfeed_mux #(.FILLER(NOP_OPCODE)) u_mux (
        .phi2_i     (phi2_i),
        .rw_i       (rw_i),
        .sync_i     (sync_i),
        .copy_i     (copy),
        .started_i  (started),
        .at_end_i   (at_end),
        .mem_data_i (mem_data_i),
        .cpu_data_o (cpu_data_o)
      );
    end else begin : g_ldy_fill
      opfeed_mux #(.FILLER(OP_LDY_IMM)) u_mux (
        .phi2_i     (phi2_i),
        .rw_i       (rw_i),
        .sync_i     (sync_i),
        .copy_i     (copy),
        .started_i  (started),
        .at_end_i   (at_end),
        .mem_data_i (mem_data_i),
        .cpu_data_o (cpu_data_o)
      );
    end
  endgenerate
endmodule

// File: rtl/opfeed_capture_chk.sv
module opfeed_capture_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              phi2_i,
  input logic              rw_i,
  input logic [7:0]        mem_data_i,
  input logic [7:0]        cpu_data_o,
  input logic              cap_we_o,
  input logic [ADDR_W-1:0] cap_addr_o,
  input logic              done_o
);
  logic [ADDR_W-1:0] last_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_addr <= '0;
    else if (cap_we_o) last_addr <= cap_addr_o;
  end

  assert_phi2_low_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phi2_i |-> cpu_data_o == mem_data_i);

  assert_write_pass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rw_i |-> cpu_data_o == mem_data_i);

  assert_addr_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_we_o && cap_addr_o != '0) |-> cap_addr_o == last_addr + ADDR_W'(1));

  assert_we_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_we_o |=> !cap_we_o);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_ret_not_captured_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cap_we_o);
endmodule

bind opfeed_capture opfeed_capture_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .phi2_i     (phi2_i),
  .rw_i       (rw_i),
  .mem_data_i (mem_data_i),
  .cpu_data_o (cpu_data_o),
  .cap_we_o   (cap_we_o),
  .cap_addr_o (cap_addr_o),
  .done_o     (done_o)
);

// File: tb/tb_opfeed_capture.sv
module tb_opfeed_capture;
  localparam int LEN_A = 21;
  localparam int LEN_B = 6;
  localparam int AW_A  = $clog2(LEN_A);
  localparam int AW_B  = $clog2(LEN_B);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phi2 = 1'b0, sync = 1'b0, rw = 1'b1, arm_a = 1'b0, arm_b = 1'b0;
  logic [7:0] mem = 8'h00;

  logic [7:0]      cpu_a, cpu_b, cd_a, cd_b;
  logic            we_a, we_b, done_a, done_b;
  logic [AW_A-1:0] ca_a;
  logic [AW_B-1:0] ca_b;

  int checks = 0, fails = 0;
  int na = 0, nb = 0, nda = 0, ndb = 0;
  int          got_addr [2][64];
  logic [7:0]  got_data [2][64];
  logic [7:0]  exp_data [64];
  logic [7:0]  lo_obs, hi_obs;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  opfeed_capture #(.BLOCK_LEN(LEN_A)) dut (
    .clk_i(clk), .rst_ni(rst_n), .phi2_i(phi2), .sync_i(sync), .rw_i(rw),
    .arm_i(arm_a), .mem_data_i(mem), .cpu_data_o(cpu_a), .cap_we_o(we_a),
    .cap_addr_o(ca_a), .cap_data_o(cd_a), .done_o(done_a));

  opfeed_capture #(.BLOCK_LEN(LEN_B), .USE_NOP_FILLER(1'b1)) dut_nop (
    .clk_i(clk), .rst_ni(rst_n), .phi2_i(phi2), .sync_i(sync), .rw_i(rw),
    .arm_i(arm_b), .mem_data_i(mem), .cpu_data_o(cpu_b), .cap_we_o(we_b),
    .cap_addr_o(ca_b), .cap_data_o(cd_b), .done_o(done_b));

  always @(negedge clk) begin
    if (we_a && na < 64) begin got_addr[0][na] = int'(ca_a); got_data[0][na] = cd_a; na++; end
    if (we_b && nb < 64) begin got_addr[1][nb] = int'(ca_b); got_data[1][nb] = cd_b; nb++; end
    if (done_a) nda++;
    if (done_b) ndb++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_cpu(input bit copying, input int captured, input int len,
                                         input bit s, input logic [7:0] filler);
    if (!copying) return 8'hxx;
    return (captured == len && s) ? 8'h60 : filler;
  endfunction

  // one bus cycle: two clocks with phi2 low, two with phi2 high
  task automatic bus_cycle(input bit s, input bit r, input logic [7:0] m, input bit aa,
                           input bit ab, input bit which);
    phi2 = 1'b0; sync = s; rw = r; mem = m; arm_a = aa; arm_b = ab;
    @(negedge clk);
    lo_obs = which ? cpu_b : cpu_a;
    @(negedge clk);
    phi2 = 1'b1;
    @(negedge clk);
    hi_obs = which ? cpu_b : cpu_a;
    @(negedge clk);
  endtask

  task automatic idle_traffic(input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] m = 8'($urandom);
      bit s = 1'($urandom), r = 1'($urandom);
      bus_cycle(s, r, m, 1'b0, 1'b0, 1'b0);
      chk(hi_obs == m && lo_obs == m, "R1 idle passthrough dut", hi_obs, m);
      chk(cpu_b == m, "R1 idle passthrough dut_nop", cpu_b, m);
    end
  endtask

  task automatic run_copy(input bit which);
    int len = which ? LEN_B : LEN_A;
    logic [7:0] filler = which ? 8'h03 : 8'hA0;
    bit jsr_rw [6] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
    bit cpu_sync = 1'b1;
    int captured = 0;
    int base_d;
    bit got_ret = 1'b0;
    na = 0; nb = 0;
    base_d = which ? ndb : nda;
    // arming store (write cycle)
    bus_cycle(1'b0, 1'b0, 8'($urandom), !which, which, which);
    for (int j = 0; j < 6; j++) begin
      logic [7:0] m = 8'($urandom);
      bus_cycle(j == 0, jsr_rw[j], m, 1'b0, 1'b0, which);
      chk(hi_obs == m, "R3 JSR cycle passes through", hi_obs, m);
    end
    for (int k = 0; k < 200 && !got_ret; k++) begin
      logic [7:0] m = 8'($urandom);
      logic [7:0] e;
      bit stray = ($urandom % 4) == 0;
      if (captured > 0 && captured < len && ($urandom % 6) == 0) begin
        bus_cycle(1'b0, 1'b0, m, !which && stray, which && stray, which);
        chk(hi_obs == m, "R6 write cycle not overridden", hi_obs, m);
        m = 8'($urandom);
      end
      bus_cycle(cpu_sync, 1'b1, m, !which && stray, which && stray, which);
      e = exp_cpu(1'b1, captured, len, cpu_sync, filler);
      chk(lo_obs == m, "R2 phi2 low passthrough", lo_obs, m);
      if (which) chk(hi_obs == e, "R10 nop filler or R7 ret", hi_obs, e);
      else if (e == 8'h60) chk(hi_obs == e, "R7 ret on opcode fetch", hi_obs, e);
      else chk(hi_obs == e, "R4 filler during copy", hi_obs, e);
      if (captured < len) begin exp_data[captured] = m; captured++; end
      if (e == 8'h60) got_ret = 1'b1;
      else cpu_sync = (filler == 8'hA0) ? !cpu_sync : 1'b1;
    end
    bus_cycle(1'b1, 1'b1, 8'h11, 1'b0, 1'b0, which);
    chk((which ? ndb : nda) - base_d == 1, "R8 one done pulse", (which ? ndb : nda) - base_d, 1);
    chk((which ? nb : na) == len, "R5 capture count (R7 none beyond block)", which ? nb : na, len);
    for (int i = 0; i < len; i++) begin
      chk(got_addr[which][i] == i, "R5 capture address order", got_addr[which][i], i);
      chk(got_data[which][i] == exp_data[i], "R5 captured byte", got_data[which][i], exp_data[i]);
    end
    // stray arms during copy must not start another one
    for (int i = 0; i < 10; i++) begin
      logic [7:0] m = 8'($urandom);
      bus_cycle(1'b1, 1'b1, m, 1'b0, 1'b0, which);
      chk(hi_obs == m, "R9 arm ignored during copy / R8 back to passthrough", hi_obs, m);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(cpu_a == mem, "R1 reset passthrough", cpu_a, mem);
    chk(!we_a && !done_a, "R5 reset no strobe", {we_a, done_a}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    idle_traffic(40);
    run_copy(1'b0);
    idle_traffic(20);
    run_copy(1'b0);
    run_copy(1'b1);
    idle_traffic(20);
    run_copy(1'b1);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule